// File: doc/BRIEF.md
# Segmented CAM Host Bus Interface

This block is the host-side front end of a content-addressable memory whose entries and wide registers are 64 bits, while the host reaches them over a 32-bit data bus. The host frames each access with an active-low enable strobe. The block samples that strobe on its system clock, and the HIGH-to-LOW transition of the strobe is the capture point. At that point the block registers the direction input, the address-valid qualifier, the 13-bit address/control bus, the segment select and the write data. It then turns them into a single request toward the array: a memory word, a 32-bit register or a 64-bit register.

A segment bit picks which 32-bit half of a 64-bit target the access touches. Writes are presented as a replicated word plus a one-hot lane mask. Reads return the selected half on the data output, and the output enable is raised only while the strobe is held LOW. In software control mode the address/control bus and its qualifier are ignored, and the access goes to the target of the most recent hardware-decoded access. A 32-bit register access made with the segment bit HIGH is rejected and flagged.

Top module: `seg_cam_hostif`

## Requirements
- R1: While en_ni is HIGH, dq_oe_o is 0. After the strobe returns HIGH, the output enable is off by the next clock.
- R2: With wr_ni HIGH, the access is a read. From the cycle after capture until the strobe rises, dq_oe_o is 1 and dq_o carries the selected half. With wr_ni LOW, the access is a write: a request with we_o = 1 is issued and dq_oe_o stays 0.
- R3: For 64-bit targets, seg_i = 0 selects bits 31..0 and seg_i = 1 selects bits 63..32. A write carries wmask_o = 2'b01 or 2'b10 respectively, and a read returns that half.
- R4: With av_ni LOW, ac_i is a memory word address. The request shows req_reg_o = 0 and addr_o = ac_i.
- R5: With av_ni HIGH, ac_i is a control code and the request shows req_reg_o = 1 and addr_o = ac_i. Bit 12 set selects a 64-bit register and bit 12 clear selects a 32-bit register. Access to a 32-bit register always uses lane 0 (wmask_o = 2'b01).
- R6: Exactly one request (req_o high for one cycle) follows each HIGH-to-LOW strobe transition, one clock after the transition is sampled. Changes to dq_i or ac_i while the strobe stays LOW have no effect.
- R7: With sw_mode_i = 1, av_ni and ac_i are ignored. The access uses the target (kind and address) of the last access made with sw_mode_i = 0.
- R8: A 32-bit register access with seg_i = 1 issues no request, drives no data and sets err_o = 1. The next accepted access clears err_o.
- R9: A half-word write leaves the other 32-bit half of the stored 64-bit word unchanged.
- R10: After reset, req_o, dq_oe_o and err_o are 0 and the held software-mode target is memory address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Access strobe, active low; falling transition captures inputs |
| wr_ni | input | 1 | Direction: LOW write, HIGH read |
| av_ni | input | 1 | Address-valid qualifier: LOW address, HIGH control code |
| seg_i | input | 1 | Segment select for the 32-bit half |
| sw_mode_i | input | 1 | Software control mode: address/control bus ignored |
| ac_i | input | 13 | Address/control bus |
| dq_i | input | 32 | Host write data |
| dq_o | output | 32 | Read data toward the host |
| dq_oe_o | output | 1 | Output enable for the bidirectional data bus |
| err_o | output | 1 | Last access rejected (32-bit register with seg_i HIGH) |
| req_o | output | 1 | One-cycle request toward the array |
| req_reg_o | output | 1 | Request targets the register space |
| we_o | output | 1 | Request is a write |
| addr_o | output | 13 | Request address or control code |
| wmask_o | output | 2 | Per-half write lane mask |
| wdata_o | output | 64 | Write data, replicated across both halves |
| rdata_i | input | 64 | Read word returned by the array in the request cycle |

## Verification
The assertions assume that en_ni is synchronous to the clock and stays at each level for at least one clock edge, so that every strobe transition is seen. They also assume that rdata_i is valid in the same cycle as req_o. The bench meets both assumptions: it changes inputs only on the falling clock edge, keeps the strobe LOW for four cycles and HIGH for at least two, and answers requests from a combinational register-file model. It also changes ac_i and dq_i on purpose in the middle of a LOW strobe, to show that only the captured values count.

// File: rtl/seg_cam_pkg.sv
package seg_cam_pkg;
  typedef enum logic [1:0] {
    TGT_MEM   = 2'd0,
    TGT_REG32 = 2'd1,
    TGT_REG64 = 2'd2
  } tgt_kind_e;
endpackage

// File: rtl/seg_cam_fall_det.sv
module seg_cam_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_ni;
  end

  assign fall_o = strobe_q & ~strobe_ni;
endmodule

// File: rtl/seg_cam_decode.sv
module seg_cam_decode
  import seg_cam_pkg::*;
#(
  parameter int unsigned AC_W  = 13,
  parameter int unsigned SEG_W = 1
) (
  input  logic             sw_mode_i,
  input  logic             av_ni,
  input  logic [AC_W-1:0]  ac_i,
  input  logic [SEG_W-1:0] seg_i,
  input  tgt_kind_e        held_kind_i,
  input  logic [AC_W-1:0]  held_addr_i,
  output tgt_kind_e        kind_o,
  output logic [AC_W-1:0]  addr_o,
  output logic             seg_bad_o
);
  always_comb begin
    if (sw_mode_i) begin
      kind_o = held_kind_i;
      addr_o = held_addr_i;
    end else if (!av_ni) begin
      kind_o = TGT_MEM;
      addr_o = ac_i;
    end else begin
      kind_o = ac_i[AC_W-1] ? TGT_REG64 : TGT_REG32;
      addr_o = ac_i;
    end
  end

  // narrow registers live in lane 0 only
  assign seg_bad_o = (kind_o == TGT_REG32) && (seg_i != '0);
endmodule

// File: rtl/seg_cam_steer.sv
module seg_cam_steer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEG_N  = 2,
  parameter int unsigned SEG_W  = 1,
  localparam int unsigned WORD_W = DATA_W * SEG_N
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [SEG_N-1:0]  mask_o,
  output logic [DATA_W-1:0] half_o
);
  for (genvar g = 0; g < SEG_N; g++) begin : g_lane
    assign mask_o[g] = (seg_i == SEG_W'(g));
  end

  always_comb begin
    half_o = '0;
    for (int i = 0; i < SEG_N; i++)
      if (mask_o[i]) half_o = word_i[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/seg_cam_hostif.sv
module seg_cam_hostif
  import seg_cam_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEG_N  = 2,
  parameter int unsigned AC_W   = 13,
  localparam int unsigned SEG_W  = (SEG_N > 1) ? $clog2(SEG_N) : 1,
  localparam int unsigned WORD_W = DATA_W * SEG_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_ni,
  input  logic              wr_ni,
  input  logic              av_ni,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic              sw_mode_i,
  input  logic [AC_W-1:0]   ac_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              err_o,
  output logic              req_o,
  output logic              req_reg_o,
  output logic              we_o,
  output logic [AC_W-1:0]   addr_o,
  output logic [SEG_N-1:0]  wmask_o,
  output logic [WORD_W-1:0] wdata_o,
  input  logic [WORD_W-1:0] rdata_i
);
  logic              fall;
  tgt_kind_e         kind_d, held_kind_q;
  logic [AC_W-1:0]   addr_d, held_addr_q, addr_q;
  logic              seg_bad;
  logic [SEG_W-1:0]  seg_q;
  logic [DATA_W-1:0] dq_q, rd_q, rd_half;
  logic              req_q, reg_q, we_q, err_q, rd_act_q;

  seg_cam_fall_det u_fall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni (en_ni),
    .fall_o    (fall)
  );

  seg_cam_decode #(.AC_W(AC_W), .SEG_W(SEG_W)) u_dec (
    .sw_mode_i   (sw_mode_i),
    .av_ni       (av_ni),
    .ac_i        (ac_i),
    .seg_i       (seg_i),
    .held_kind_i (held_kind_q),
    .held_addr_i (held_addr_q),
    .kind_o      (kind_d),
    .addr_o      (addr_d),
    .seg_bad_o   (seg_bad)
  );

  seg_cam_steer #(.DATA_W(DATA_W), .SEG_N(SEG_N), .SEG_W(SEG_W)) u_steer (
    .seg_i  (seg_q),
    .word_i (rdata_i),
    .mask_o (wmask_o),
    .half_o (rd_half)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_kind_q <= TGT_MEM;
      held_addr_q <= '0;
      addr_q      <= '0;
      seg_q       <= '0;
      dq_q        <= '0;
      rd_q        <= '0;
      req_q       <= 1'b0;
      reg_q       <= 1'b0;
      we_q        <= 1'b0;
      err_q       <= 1'b0;
      rd_act_q    <= 1'b0;
    end else begin
      if (fall) begin
        held_kind_q <= kind_d;  // in software mode decode returns the held value
        held_addr_q <= addr_d;
        addr_q      <= addr_d;
        reg_q       <= (kind_d != TGT_MEM);
        seg_q       <= seg_i;
        dq_q        <= dq_i;
        we_q        <= ~wr_ni;
        req_q       <= ~seg_bad;
        err_q       <= seg_bad;
        rd_act_q    <= wr_ni & ~seg_bad;
      end else begin
        req_q <= 1'b0;
        if (en_ni) rd_act_q <= 1'b0;
      end
      if (req_q && !we_q) rd_q <= rd_half;
    end
  end

  assign req_o     = req_q;
  assign req_reg_o = reg_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign wdata_o   = {SEG_N{dq_q}};
  assign err_o     = err_q;
  assign dq_o      = rd_q;
  assign dq_oe_o   = rd_act_q & ~en_ni;
endmodule

// File: rtl/seg_cam_hostif_chk.sv
module seg_cam_hostif_chk #(
  parameter int unsigned SEG_N = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_ni,
  input logic             dq_oe_o,
  input logic             err_o,
  input logic             req_o,
  input logic             we_o,
  input logic [SEG_N-1:0] wmask_o
);
  p_oe_needs_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !en_ni && !$past(en_ni));

  p_oe_not_on_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !we_o);

  p_one_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> ($countones(wmask_o) == 1));

  p_req_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  p_req_after_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !$past(en_ni));

  p_err_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !req_o && !dq_oe_o);
endmodule

bind seg_cam_hostif seg_cam_hostif_chk #(.SEG_N(SEG_N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_ni   (en_ni),
  .dq_oe_o (dq_oe_o),
  .err_o   (err_o),
  .req_o   (req_o),
  .we_o    (we_o),
  .wmask_o (wmask_o)
);

// File: tb/seg_cam_hostif_test.sv
`timescale 1ns/1ps
module seg_cam_hostif_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_ni = 1'b1, wr_ni = 1'b1, av_ni = 1'b0, seg_i = 1'b0, sw_mode_i = 1'b0;
  logic [12:0] ac_i = '0;
  logic [31:0] dq_i = '0, dq_o;
  logic        dq_oe_o, err_o, req_o, req_reg_o, we_o;
  logic [12:0] addr_o;
  logic [1:0]  wmask_o;
  logic [63:0] wdata_o, rdata_i;

  always #5 clk = ~clk;

  seg_cam_hostif uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni), .wr_ni(wr_ni), .av_ni(av_ni),
    .seg_i(seg_i), .sw_mode_i(sw_mode_i), .ac_i(ac_i), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .err_o(err_o), .req_o(req_o), .req_reg_o(req_reg_o),
    .we_o(we_o), .addr_o(addr_o), .wmask_o(wmask_o), .wdata_o(wdata_o),
    .rdata_i(rdata_i)
  );

  // array model: memory words and register file, 16 entries each
  logic [63:0] mem [16];
  logic [63:0] regs [16];
  int          req_cnt = 0;
  logic        last_reg;
  logic [12:0] last_addr;
  logic [1:0]  last_mask;

  assign rdata_i = req_reg_o ? regs[addr_o[3:0]] : mem[addr_o[3:0]];

  always @(posedge clk) begin
    if (req_o) begin
      req_cnt   <= req_cnt + 1;
      last_reg  <= req_reg_o;
      last_addr <= addr_o;
      last_mask <= wmask_o;
      if (we_o)
        for (int l = 0; l < 2; l++)
          if (wmask_o[l]) begin
            if (req_reg_o) regs[addr_o[3:0]][l*32 +: 32] <= wdata_o[l*32 +: 32];
            else           mem[addr_o[3:0]][l*32 +: 32]  <= wdata_o[l*32 +: 32];
          end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr_n, input logic av_n, input logic seg,
                        input logic [12:0] ac, input logic [31:0] dq,
                        output logic [31:0] rd, output logic oe_low,
                        output logic err, output logic oe_high);
    @(negedge clk);
    wr_ni = wr_n; av_ni = av_n; seg_i = seg; ac_i = ac; dq_i = dq;
    @(negedge clk);
    en_ni = 1'b0;
    repeat (4) @(negedge clk);
    rd = dq_o; oe_low = dq_oe_o; err = err_o;
    en_ni = 1'b1;
    @(negedge clk);
    oe_high = dq_oe_o;
  endtask

  typedef struct packed {
    logic        wr_n;
    logic        av_n;
    logic        seg;
    logic [12:0] ac;
    logic [31:0] dq;
    logic [31:0] exp;
    logic        exp_err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 13'h0003, 32'hA000_0003, 32'h0,         1'b0},
    '{1'b0, 1'b0, 1'b1, 13'h0003, 32'hB000_0003, 32'h0,         1'b0},
    '{1'b1, 1'b0, 1'b0, 13'h0003, 32'h0,         32'hA000_0003, 1'b0},
    '{1'b1, 1'b0, 1'b1, 13'h0003, 32'h0,         32'hB000_0003, 1'b0},
    '{1'b0, 1'b0, 1'b0, 13'h0003, 32'hC000_0003, 32'h0,         1'b0},
    '{1'b1, 1'b0, 1'b1, 13'h0003, 32'h0,         32'hB000_0003, 1'b0},
    '{1'b1, 1'b0, 1'b0, 13'h0003, 32'h0,         32'hC000_0003, 1'b0},
    '{1'b0, 1'b1, 1'b0, 13'h0002, 32'h1234_5678, 32'h0,         1'b0},
    '{1'b1, 1'b1, 1'b0, 13'h0002, 32'h0,         32'h1234_5678, 1'b0},
    '{1'b0, 1'b1, 1'b1, 13'h0002, 32'hFFFF_FFFF, 32'h0,         1'b1},
    '{1'b1, 1'b1, 1'b0, 13'h0002, 32'h0,         32'h1234_5678, 1'b0},
    '{1'b0, 1'b1, 1'b1, 13'h1005, 32'h5A5A_5A5A, 32'h0,         1'b0},
    '{1'b1, 1'b1, 1'b1, 13'h1005, 32'h0,         32'h5A5A_5A5A, 1'b0},
    '{1'b1, 1'b0, 1'b1, 13'h0002, 32'h0,         32'h0,         1'b0},
    '{1'b1, 1'b1, 1'b1, 13'h0002, 32'h0,         32'h0,         1'b1}
  };

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; regs[i] = '0; end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        oe_l, er, oe_h;
    int          c0;
    logic [1:0]  exp_mask;

    repeat (3) @(negedge clk);
    chk("R10 req after reset", req_o, 0);
    chk("R10 oe after reset", dq_oe_o, 0);
    chk("R10 err after reset", err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7 / R10: software mode before any hardware access uses memory address 0
    sw_mode_i = 1'b1;
    access(1'b0, 1'b1, 1'b1, 13'h1007, 32'hDEAD_0000, rd, oe_l, er, oe_h);
    sw_mode_i = 1'b0;
    chk("R10 held target is memory", last_reg, 0);
    chk("R10 held address is 0", last_addr, 0);

    for (int v = 0; v < NV; v++) begin
      c0 = req_cnt;
      access(VECS[v].wr_n, VECS[v].av_n, VECS[v].seg, VECS[v].ac, VECS[v].dq,
             rd, oe_l, er, oe_h);
      chk("R8 err flag", er, VECS[v].exp_err);
      chk("R6 requests per strobe", req_cnt - c0, VECS[v].exp_err ? 0 : 1);
      chk("R1 oe off after strobe rises", oe_h, 0);
      if (VECS[v].exp_err) begin
        chk("R8 no drive on rejected access", oe_l, 0);
      end else begin
        chk("R4 R5 request space", last_reg, VECS[v].av_n);
        chk("R4 R5 request address", last_addr, VECS[v].ac);
        if (!VECS[v].wr_n) begin
          exp_mask = (VECS[v].av_n && !VECS[v].ac[12]) ? 2'b01 :
                     (VECS[v].seg ? 2'b10 : 2'b01);
          chk("R3 R5 write lane mask", last_mask, exp_mask);
          chk("R2 no drive on write", oe_l, 0);
        end else begin
          chk("R2 oe on read", oe_l, 1);
          chk("R3 R9 read half", rd, VECS[v].exp);
        end
      end
    end
    chk("R9 stored word halves", mem[3], 64'hB000_0003_C000_0003);
    chk("R8 rejected write left register", regs[2], 64'h0000_0000_1234_5678);

    // R6: bus changes during a LOW strobe are ignored
    @(negedge clk);
    wr_ni = 1'b0; av_ni = 1'b0; seg_i = 1'b0; ac_i = 13'h0007; dq_i = 32'h1111_1111;
    @(negedge clk);
    en_ni = 1'b0;
    repeat (2) @(negedge clk);
    ac_i = 13'h0008; dq_i = 32'h2222_2222;
    repeat (2) @(negedge clk);
    en_ni = 1'b1;
    access(1'b1, 1'b0, 1'b0, 13'h0007, 32'h0, rd, oe_l, er, oe_h);
    chk("R6 captured data kept", rd, 32'h1111_1111);
    access(1'b1, 1'b0, 1'b0, 13'h0008, 32'h0, rd, oe_l, er, oe_h);
    chk("R6 late address ignored", rd, 32'h0);

    // R7: software mode follows the last hardware target
    access(1'b1, 1'b0, 1'b1, 13'h0003, 32'h0, rd, oe_l, er, oe_h);
    sw_mode_i = 1'b1;
    access(1'b1, 1'b1, 1'b1, 13'h1005, 32'h0, rd, oe_l, er, oe_h);
    chk("R7 sw read uses held target", rd, 32'hB000_0003);
    chk("R7 sw request space", last_reg, 0);
    chk("R7 sw request address", last_addr, 13'h0003);
    access(1'b0, 1'b0, 1'b0, 13'h0009, 32'h7777_7777, rd, oe_l, er, oe_h);
    sw_mode_i = 1'b0;
    access(1'b1, 1'b0, 1'b0, 13'h0003, 32'h0, rd, oe_l, er, oe_h);
    chk("R7 sw write reached held target", rd, 32'h7777_7777);
    access(1'b1, 1'b0, 1'b0, 13'h0009, 32'h0, rd, oe_l, er, oe_h);
    chk("R7 sw write ignored bus address", rd, 32'h0);

    // R8: error clears on the next accepted access
    access(1'b1, 1'b1, 1'b1, 13'h0004, 32'h0, rd, oe_l, er, oe_h);
    chk("R8 error set", er, 1);
    access(1'b1, 1'b1, 1'b0, 13'h0004, 32'h0, rd, oe_l, er, oe_h);
    chk("R8 error cleared", er, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule